// File: doc/BRIEF.md
# Four-Channel Operating-System Match Timer

This block is a memory-mapped system timer built around one shared 32-bit up-counter and four match channels. The counter advances by one on every clock cycle in which an external prescaler raises its tick-enable strobe. It wraps from all-ones to zero. Each channel holds a 32-bit match value. When a tick brings the counter onto that value, the channel records a status bit and raises its own interrupt line, but only if software has enabled that channel.

Software clears a status bit by writing a one to it. Writing a one to a bit that is not set changes nothing. The highest channel can also act as a watchdog. Once software arms it, the next match on that channel issues a one-cycle system reset request and disarms the watchdog. Software can arm the watchdog but cannot disarm it.

Software reads and writes the registers through a simple bus with a one-cycle read latency. A read of an offset that is not mapped returns zero and flags a bus error.

Top module: `os_match_timer`

## Requirements
- R1: The registers decode at byte offsets that are multiples of four. Match 0 to 3 sit at 0x00, 0x04, 0x08 and 0x0C, the counter at 0x10, status at 0x14, watchdog arm at 0x18 and interrupt enable at 0x1C. Read data appears on the cycle after the read request.
- R2: A match sets status bit n only when interrupt-enable bit n is 1. A match on a disabled channel sets no status bit, raises no interrupt, and leaves no pending state that a later enable could expose.
- R3: A status write clears only the bits that are both written as 1 and currently set. Clearing bit n drops interrupt line n.
- R4: Interrupt line n (bit n of `irq`) follows status bit n alone. A match on one channel leaves the other lines unchanged.
- R5: When the watchdog is armed and channel 3 matches, `reset_req` is high for exactly one cycle and the watchdog disarms. This happens whether or not channel 3's interrupt is enabled. A match while the watchdog is disarmed gives no request.
- R6: The interrupt-enable register keeps bits 11:0 of a write. Bits 31:12 read back as zero.
- R7: A counter write loads the written value, and counting resumes upward from it. The load cycle never produces a match, even when the loaded value equals a match value.
- R8: The counter adds one on each cycle with `tick_en` high and holds otherwise. It wraps from 0xFFFFFFFF to 0, and a match value of 0 is hit on the wrap.
- R9: A read of an unmapped or misaligned offset returns 0 with `bus_err` high for that one response cycle. A write to such an offset changes no register.
- R10: Reset clears every match register, the counter, status, interrupt enables, the watchdog arm, all interrupt lines and `reset_req`.
- R11: Writing bit 0 of the watchdog register as 1 arms it. Writing 0 while it is armed leaves it armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count strobe from the external prescaler |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_err | output | 1 | One-cycle error on an unmapped read |
| irq | output | 4 | One interrupt line per channel |
| reset_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The bench probes the tick one before a match and the tick of the match. A comparator that used the old count would fire one tick late. The bench also loads the counter with a value equal to a match, which would fire a spurious interrupt if the load cycle were compared. It checks wrapping onto a match value of zero, clear-by-one writes aimed at bits that are not set, and enabling a channel after its disabled match. A design that kept hidden pending state would expose an interrupt at that enable. Finally, it tries to disarm the armed watchdog, lets it trigger with its interrupt masked, and checks that the request lasts one cycle and that a later match does not repeat it.

// File: rtl/omt_pkg.sv
package omt_pkg;
  localparam int NUM_CH   = 4;
  localparam int CNT_W    = 32;
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int WD_CH    = NUM_CH - 1;

  typedef enum logic [2:0] {
    SLOT_M0   = 3'd0,
    SLOT_M1   = 3'd1,
    SLOT_M2   = 3'd2,
    SLOT_M3   = 3'd3,
    SLOT_CNT  = 3'd4,
    SLOT_STAT = 3'd5,
    SLOT_WDOG = 3'd6,
    SLOT_IEN  = 3'd7
  } slot_e;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  // a channel hits on the tick that moves the counter onto its value
  function automatic logic match_hit(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] m,
                                     input logic tick, input logic load);
    return tick && !load && (cnt_step(c) == m);
  endfunction

  function automatic logic [NUM_CH-1:0] status_next(input logic [NUM_CH-1:0] cur,
                                                    input logic [NUM_CH-1:0] clr,
                                                    input logic [NUM_CH-1:0] set);
    return (cur & ~(clr & cur)) | set;
  endfunction
endpackage

// File: rtl/omt_counter.sv
module omt_counter (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_en,
  input  logic                       load,
  input  logic [omt_pkg::CNT_W-1:0]  load_val,
  output logic [omt_pkg::CNT_W-1:0]  cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= load_val;
    else if (tick_en) cnt <= omt_pkg::cnt_step(cnt);
  end
endmodule

// File: rtl/omt_channel.sv
module omt_channel (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [omt_pkg::CNT_W-1:0]  wr_val,
  input  logic [omt_pkg::CNT_W-1:0]  cnt,
  input  logic                       tick_en,
  input  logic                       cnt_load,
  output logic [omt_pkg::CNT_W-1:0]  match_val,
  output logic                       hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)     match_val <= '0;
    else if (wr_en) match_val <= wr_val;
  end

  assign hit = omt_pkg::match_hit(cnt, match_val, tick_en, cnt_load);
endmodule

// File: rtl/omt_busdec.sv
module omt_busdec #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IEN_W  = 12
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            sel,
  input  logic                                            we,
  input  logic [ADDR_W-1:0]                               addr,
  input  logic [omt_pkg::NUM_CH-1:0][omt_pkg::CNT_W-1:0]  match_vals,
  input  logic [omt_pkg::CNT_W-1:0]                       cnt,
  input  logic [omt_pkg::NUM_CH-1:0]                      status,
  input  logic                                            wdog_en,
  input  logic [IEN_W-1:0]                                ien,
  output logic [omt_pkg::NUM_CH-1:0]                      wr_match,
  output logic                                            wr_cnt,
  output logic                                            wr_stat,
  output logic                                            wr_wdog,
  output logic                                            wr_ien,
  output logic [DATA_W-1:0]                               rdata,
  output logic                                            err
);
  import omt_pkg::*;

  logic              map_hit;
  logic              wr_go;
  slot_e             slot;
  logic [DATA_W-1:0] rd_val;

  assign map_hit = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:5] == '0);
  assign slot    = slot_e'(addr[4:2]);
  assign wr_go   = sel && we && map_hit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wr
    assign wr_match[g] = wr_go && (addr[4:2] == 3'(g));
  end

  assign wr_cnt  = wr_go && (slot == SLOT_CNT);
  assign wr_stat = wr_go && (slot == SLOT_STAT);
  assign wr_wdog = wr_go && (slot == SLOT_WDOG);
  assign wr_ien  = wr_go && (slot == SLOT_IEN);

  always_comb begin
    case (slot)
      SLOT_CNT:  rd_val = DATA_W'(cnt);
      SLOT_STAT: rd_val = DATA_W'(status);
      SLOT_WDOG: rd_val = DATA_W'(wdog_en);
      SLOT_IEN:  rd_val = DATA_W'(ien);
      default:   rd_val = DATA_W'(match_vals[addr[CH_IDX_W+1:2]]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else if (sel && !we) begin
      rdata <= map_hit ? rd_val : '0;
      err   <= !map_hit;
    end else begin
      rdata <= '0;
      err   <= 1'b0;
    end
  end
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IEN_W  = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_en,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        bus_err,
  output logic [omt_pkg::NUM_CH-1:0]  irq,
  output logic                        reset_req
);
  import omt_pkg::*;

  logic [CNT_W-1:0]             cnt;
  logic                         cnt_load;
  logic [NUM_CH-1:0][CNT_W-1:0] match_vals;
  logic [NUM_CH-1:0]            hit;
  logic [NUM_CH-1:0]            wr_match;
  logic                         wr_stat, wr_wdog, wr_ien;
  logic [NUM_CH-1:0]            status;
  logic [IEN_W-1:0]             ien;
  logic                         wdog_en;
  logic                         wdog_fire;
  logic [NUM_CH-1:0]            stat_set;
  logic [NUM_CH-1:0]            stat_clr;

  omt_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load     (cnt_load),
    .load_val (bus_wdata[CNT_W-1:0]),
    .cnt      (cnt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    omt_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_match[g]),
      .wr_val    (bus_wdata[CNT_W-1:0]),
      .cnt       (cnt),
      .tick_en   (tick_en),
      .cnt_load  (cnt_load),
      .match_val (match_vals[g]),
      .hit       (hit[g])
    );
  end

  omt_busdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IEN_W(IEN_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (bus_sel),
    .we         (bus_we),
    .addr       (bus_addr),
    .match_vals (match_vals),
    .cnt        (cnt),
    .status     (status),
    .wdog_en    (wdog_en),
    .ien        (ien),
    .wr_match   (wr_match),
    .wr_cnt     (cnt_load),
    .wr_stat    (wr_stat),
    .wr_wdog    (wr_wdog),
    .wr_ien     (wr_ien),
    .rdata      (bus_rdata),
    .err        (bus_err)
  );

  assign stat_set  = hit & ien[NUM_CH-1:0];
  assign stat_clr  = wr_stat ? bus_wdata[NUM_CH-1:0] : '0;
  assign wdog_fire = hit[WD_CH] && wdog_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status    <= '0;
      ien       <= '0;
      wdog_en   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      status    <= status_next(status, stat_clr, stat_set);
      reset_req <= wdog_fire;
      if (wr_ien) ien <= bus_wdata[IEN_W-1:0];
      if (wdog_fire)                    wdog_en <= 1'b0;
      else if (wr_wdog && bus_wdata[0]) wdog_en <= 1'b1;
    end
  end

  assign irq = status;
endmodule

// File: rtl/omt_checker.sv
module omt_checker (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick_en,
  input logic                       cnt_load,
  input logic [omt_pkg::CNT_W-1:0]  cnt,
  input logic [omt_pkg::NUM_CH-1:0] hit,
  input logic [omt_pkg::NUM_CH-1:0] ien_lo,
  input logic [omt_pkg::NUM_CH-1:0] status,
  input logic                       wdog_en,
  input logic                       reset_req,
  input logic                       bus_err,
  input logic [31:0]                bus_rdata
);
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_load) |=> $stable(cnt)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_load) |=> (cnt == $past(cnt) + 1'b1)); // R8
  AST_LOAD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |-> (hit == '0)); // R7
  AST_STATUS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(hit & ien_lo)) == '0); // R2
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req); // R5
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(hit[omt_pkg::WD_CH] && wdog_en)); // R5
  AST_WDOG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !wdog_en); // R5
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0)); // R9
endmodule

bind os_match_timer omt_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .cnt_load  (cnt_load),
  .cnt       (cnt),
  .hit       (hit),
  .ien_lo    (ien[omt_pkg::NUM_CH-1:0]),
  .status    (status),
  .wdog_en   (wdog_en),
  .reset_req (reset_req),
  .bus_err   (bus_err),
  .bus_rdata (bus_rdata[31:0])
);

// File: tb/tb_os_match_timer.sv
`timescale 1ns/1ps
module tb_os_match_timer;
  localparam logic [7:0] A_M0 = 8'h00, A_M1 = 8'h04, A_M2 = 8'h08, A_M3 = 8'h0C;
  localparam logic [7:0] A_CNT = 8'h10, A_ST = 8'h14, A_WD = 8'h18, A_IE = 8'h1C;

  logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [3:0]  irq;
  logic        reset_req;

  always #10 clk = ~clk;

  os_match_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq(irq), .reset_req(reset_req)
  );

  int n_chk = 0, n_fail = 0, rr_cnt = 0;
  logic [31:0] exp_d_q[$];
  logic        exp_e_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= bus_sel & ~bus_we;
  always @(negedge clk) begin
    if (reset_req) rr_cnt++;
    if (rd_seen) begin
      if (exp_d_q.size() == 0) chk(1'b0, "scoreboard underflow", 32'h0, 32'h1);
      else begin
        logic [31:0] ed;
        logic        ee;
        string       t;
        ed = exp_d_q.pop_front();
        ee = exp_e_q.pop_front();
        t  = tag_q.pop_front();
        chk(bus_rdata == ed, {t, " data"}, bus_rdata, ed);
        chk(bus_err == ee, {t, " err"}, 32'(bus_err), 32'(ee));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] d, input logic e, input string tag);
    @(negedge clk);
    exp_d_q.push_back(d); exp_e_q.push_back(e); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq == 4'h0 && reset_req == 1'b0, "R10 outputs in reset", {27'h0, reset_req, irq}, 32'h0);
    rst_n = 1'b1;
    // R10: every register reads zero after reset
    rd(A_M0, 0, 0, "R10 match0"); rd(A_M1, 0, 0, "R10 match1");
    rd(A_M2, 0, 0, "R10 match2"); rd(A_M3, 0, 0, "R10 match3");
    rd(A_CNT, 0, 0, "R10 counter"); rd(A_ST, 0, 0, "R10 status");
    rd(A_WD, 0, 0, "R10 wdog"); rd(A_IE, 0, 0, "R10 ien");

    // R1: offsets of the match registers
    wr(A_M0, 32'h11); wr(A_M1, 32'h22); wr(A_M2, 32'h33); wr(A_M3, 32'h44);
    rd(A_M0, 32'h11, 0, "R1 match0"); rd(A_M1, 32'h22, 0, "R1 match1");
    rd(A_M2, 32'h33, 0, "R1 match2"); rd(A_M3, 32'h44, 0, "R1 match3");

    // R6: enable keeps 12 bits
    wr(A_IE, 32'hFFFF_FFFF);
    rd(A_IE, 32'h0000_0FFF, 0, "R6 ien width");
    wr(A_IE, 32'h1);

    // R2/R8: enabled match fires on the tick that reaches the value
    wr(A_M0, 5); wr(A_M1, 7); wr(A_M2, 10);
    ticks(4);
    chk(irq == 4'h0, "R2 before match", 32'(irq), 32'h0);
    ticks(1);
    chk(irq == 4'h1, "R2 match0 irq", 32'(irq), 32'h1);
    rd(A_CNT, 5, 0, "R8 count after 5 ticks");
    ticks(2);
    chk(irq == 4'h1, "R2 disabled match1 no irq", 32'(irq), 32'h1);
    rd(A_ST, 32'h1, 0, "R2 disabled match1 no status");
    wr(A_IE, 32'h3);
    rd(A_ST, 32'h1, 0, "R2 enable after match leaves no trace");
    chk(irq == 4'h1, "R2 enable after match irq", 32'(irq), 32'h1);

    // R3: clear by writing ones
    wr(A_ST, 32'h6);
    rd(A_ST, 32'h1, 0, "R3 write to unset bits");
    chk(irq == 4'h1, "R3 irq kept", 32'(irq), 32'h1);
    wr(A_ST, 32'hF);
    rd(A_ST, 32'h0, 0, "R3 cleared");
    chk(irq == 4'h0, "R3 irq dropped", 32'(irq), 32'h0);

    // R4: separate lines
    wr(A_IE, 32'h5);
    ticks(3);
    chk(irq == 4'h4, "R4 only line 2", 32'(irq), 32'h4);
    rd(A_ST, 32'h4, 0, "R4 status bit 2");
    wr(A_ST, 32'h4);

    // R8/R7: load near the top and wrap onto match 0
    wr(A_M3, 0); wr(A_IE, 32'h8);
    wr(A_CNT, 32'hFFFF_FFFE);
    rd(A_CNT, 32'hFFFF_FFFE, 0, "R7 load value");
    ticks(1);
    chk(irq == 4'h0, "R8 before wrap", 32'(irq), 32'h0);
    ticks(1);
    chk(irq == 4'h8, "R8 wrap hits match 0", 32'(irq), 32'h8);
    rd(A_CNT, 0, 0, "R8 wrapped count");
    wr(A_ST, 32'h8);

    // R7: load equal to a match value is not a match
    wr(A_M0, 100); wr(A_IE, 32'h1);
    wr(A_CNT, 100);
    chk(irq == 4'h0, "R7 no match on load", 32'(irq), 32'h0);
    rd(A_ST, 0, 0, "R7 status after load");
    ticks(1);
    rd(A_CNT, 101, 0, "R7 counts on from load");
    wr(A_CNT, 99);
    ticks(1);
    chk(irq == 4'h1, "R7 match after reload", 32'(irq), 32'h1);
    wr(A_ST, 32'h1);

    // R11 / R5: watchdog
    wr(A_IE, 32'h0); wr(A_M3, 200);
    wr(A_WD, 1);
    rd(A_WD, 1, 0, "R11 armed");
    wr(A_WD, 0);
    rd(A_WD, 1, 0, "R11 cannot disarm");
    wr(A_CNT, 197);
    ticks(2);
    repeat (2) @(negedge clk);
    chk(rr_cnt == 0, "R5 no early request", 32'(rr_cnt), 32'h0);
    ticks(1);
    repeat (2) @(negedge clk);
    chk(rr_cnt == 1, "R5 one-cycle request", 32'(rr_cnt), 32'h1);
    rd(A_WD, 0, 0, "R5 watchdog disarmed");
    rd(A_ST, 0, 0, "R5 masked channel no status");
    wr(A_CNT, 199);
    ticks(1);
    repeat (2) @(negedge clk);
    chk(rr_cnt == 1, "R5 no repeat when disarmed", 32'(rr_cnt), 32'h1);

    // R9: unmapped accesses
    rd(8'h20, 0, 1, "R9 unmapped read");
    rd(8'h03, 0, 1, "R9 misaligned read");
    rd(8'h40, 0, 1, "R9 high offset read");
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(A_CNT, 200, 0, "R9 counter untouched");
    rd(A_M0, 100, 0, "R9 match0 untouched");
    rd(A_IE, 0, 0, "R9 ien untouched");
    rd(A_WD, 0, 0, "R9 wdog untouched");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule